// File: doc/BRIEF.md
# UART Interrupt Identification and Arbitration

This block collects the interrupt causes of a UART and turns them into requests for the rest of the chip. It tracks three sources: receive line errors (overrun, parity, framing, break), a received word waiting in the receive buffer, and an empty transmit holding register. Each source has its own enable bit and its own pending state. Each pending state drives its own request line, so a system interrupt controller can service the three separately. The same states are also folded into an 8-bit identification value with a fixed priority, for software that services all UART causes from one routine.

Each of the two simple sources (line errors and receive data) is held by a two-state machine with the states `LT_IDLE` and `LT_PEND`. The machine moves `LT_IDLE -> LT_PEND` on an enabled event. It moves `LT_PEND -> LT_IDLE` on the source's clear strobe, or when its enable is low. An enabled event in the same cycle as the clear keeps or enters `LT_PEND`.

The transmit source is a two-state machine with the states `TX_QUIET` and `TX_REQ`. It moves `TX_QUIET -> TX_REQ` on an arm condition: the enable rises while the holding register is empty, or the holding register becomes empty while enabled. It moves `TX_REQ -> TX_QUIET` in three cases: on a holding-register write, when the enable is low, or on an identification read that returns the transmit code 0x02. An identification read that returns 0x04 or 0x06 leaves `TX_REQ` in place. This lets a service routine that stops sending drop the transmit request just by reading the identification value.

Top module: `uart_irq_ident`

## Requirements
- R1: Each source drives only its own request output: `irq_line` for line errors, `irq_rx` for receive data and `irq_tx` for transmit empty. Each request rises in the cycle after the clock edge that samples its enabled event.
- R2: `irq_line` is set by any bit of `err_ev` when `en_line` is high. The bits of `err_ev` are bit 0 overrun, bit 1 parity, bit 2 framing and bit 3 break. With `en_line` low, error events have no effect.
- R3: `ident` reports the highest-priority pending source in bits [2:1]. The order is line errors (0x06), then receive data (0x04), then transmit empty (0x02), and bits above 2 are zero.
- R4: `ident[0]` is 0 whenever any request is pending. With no request pending, `ident` is 0x01.
- R5: With `thr_empty` high, raising `en_tx` sets `irq_tx` one cycle later. With `en_tx` high, a rise of `thr_empty` also sets `irq_tx` one cycle later.
- R6: A `hold_wr` strobe clears `irq_tx` in the next cycle, and takes precedence over any arm condition in the same cycle.
- R7: An `ident_rd` strobe while `ident` reads 0x02 clears `irq_tx` in the next cycle.
- R8: An `ident_rd` strobe while `ident` reads 0x04 or 0x06 leaves `irq_tx` set.
- R9: A `rxbuf_rd` strobe clears `irq_rx`, unless an enabled `rx_ready` event arrives in the same cycle, in which case `irq_rx` stays set.
- R10: A `linestat_rd` strobe clears `irq_line`.
- R11: Dropping a source's enable clears that source's request in the next cycle.
- R12: After reset all three requests are low and `ident` reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_line | input | 1 | Enable for line error interrupts |
| en_rx | input | 1 | Enable for receive data interrupts |
| en_tx | input | 1 | Enable for transmit empty interrupts |
| err_ev | input | ERR_W (4) | Error event pulses: bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break |
| rx_ready | input | 1 | Pulse when a received word enters the receive buffer |
| thr_empty | input | 1 | Level: the transmit holding register is empty |
| hold_wr | input | 1 | Strobe: write to the transmit holding register |
| ident_rd | input | 1 | Strobe: read of the identification value |
| rxbuf_rd | input | 1 | Strobe: read of the receive buffer |
| linestat_rd | input | 1 | Strobe: read of the line status |
| irq_line | output | 1 | Line error request |
| irq_rx | output | 1 | Receive data request |
| irq_tx | output | 1 | Transmit empty request |
| ident | output | IDENT_W (8) | Identification value |

## Verification
Every state of this block is visible at the ports. If a pending state is wrong, the matching request line shows it, and `ident` carries the wrong code, in the cycle after the clock edge that caused it. An error in the transmit clear rule (a read at 0x04 or 0x06 that drops the transmit latch, or a read at 0x02 that does not) shows up on `irq_tx` one cycle after the read strobe. It shows up on `ident` once the higher sources have been cleared. The bench runs a behavioural model alongside the design and compares all outputs on every cycle, so any such divergence is reported within one clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // state of a simple set/clear interrupt source
    typedef enum logic {
        LT_IDLE = 1'b0,
        LT_PEND = 1'b1
    } latch_state_t;

    // state of the transmit-empty source
    typedef enum logic {
        TX_QUIET = 1'b0,
        TX_REQ   = 1'b1
    } tx_state_t;

    // codes for ident[2:1], highest priority first
    localparam logic [1:0] CODE_LINE = 2'd3;
    localparam logic [1:0] CODE_RX   = 2'd2;
    localparam logic [1:0] CODE_TX   = 2'd1;
    localparam logic [1:0] CODE_NONE = 2'd0;

    // index of each simple source in the generated latch array
    localparam int SRC_LINE = 0;
    localparam int SRC_RX   = 1;
    localparam int N_SIMPLE = 2;

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_ev,
    input  logic clr_ev,
    output logic pend
);

    latch_state_t state_q;
    latch_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: an enabled event wins over a clear in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LT_IDLE: begin
                if (enable && set_ev) begin
                    state_d = LT_PEND;
                end
            end
            LT_PEND: begin
                if (!enable) begin
                    state_d = LT_IDLE;
                end else if (clr_ev && !set_ev) begin
                    state_d = LT_IDLE;
                end
            end
            default: state_d = LT_IDLE;
        endcase
    end

    // output
    always_comb begin
        pend = (state_q == LT_PEND);
    end

    // R1, R2, R9: an enabled event always leaves the source pending
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && set_ev) |=> pend);

    // R9, R10: a clear without a new event drops the source
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev && !set_ev) |=> !pend);

    // R11: a low enable never leaves a pending source behind
    a_r11_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pend);

endmodule

// File: rtl/irq_tx_fsm.sv
module irq_tx_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic thr_empty,
    input  logic hold_wr,
    input  logic ident_rd,
    input  logic higher_pend,
    output logic pend
);

    tx_state_t state_q;
    tx_state_t state_d;
    logic      en_q;
    logic      empty_q;
    logic      arm;
    logic      rd_clear;

    // state register and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_QUIET;
            en_q    <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= enable;
            empty_q <= thr_empty;
        end
    end

    // arm on enable rising while empty, or empty rising while enabled
    always_comb begin
        arm      = enable && thr_empty && !(en_q && empty_q);
        rd_clear = ident_rd && !higher_pend;
    end

    // next state: write / disable beat arm; arm beats an identification read
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_QUIET: begin
                if (arm && !hold_wr) begin
                    state_d = TX_REQ;
                end
            end
            TX_REQ: begin
                if (hold_wr || !enable) begin
                    state_d = TX_QUIET;
                end else if (rd_clear && !arm) begin
                    state_d = TX_QUIET;
                end
            end
            default: state_d = TX_QUIET;
        endcase
    end

    // output
    always_comb begin
        pend = (state_q == TX_REQ);
    end

    // R5: enable rising over an empty holding register raises the request
    a_r5_enable_arms: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(enable) && thr_empty && !hold_wr) |=> pend);

    // R6: a holding-register write clears the request
    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |=> !pend);

    // R8: a read while a higher source is pending keeps the request
    a_r8_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && ident_rd && higher_pend && enable && !hold_wr) |=> pend);

    // R7: a read with nothing higher pending and no new arm clears it
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && ident_rd && !higher_pend && !arm) |=> !pend);

endmodule

// File: rtl/irq_ident_enc.sv
module irq_ident_enc
    import uart_irq_pkg::*;
#(
    parameter int IDENT_W = 8
) (
    input  logic               line_pend,
    input  logic               rx_pend,
    input  logic               tx_pend,
    output logic [IDENT_W-1:0] ident
);

    logic [1:0] code;

    // fixed priority: line errors, then receive data, then transmit empty
    always_comb begin
        if (line_pend) begin
            code = CODE_LINE;
        end else if (rx_pend) begin
            code = CODE_RX;
        end else if (tx_pend) begin
            code = CODE_TX;
        end else begin
            code = CODE_NONE;
        end
    end

    always_comb begin
        ident       = '0;
        ident[2:1]  = code;
        ident[0]    = (code == CODE_NONE);
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ERR_W   = 4,
    parameter int IDENT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_line,
    input  logic               en_rx,
    input  logic               en_tx,
    input  logic [ERR_W-1:0]   err_ev,
    input  logic               rx_ready,
    input  logic               thr_empty,
    input  logic               hold_wr,
    input  logic               ident_rd,
    input  logic               rxbuf_rd,
    input  logic               linestat_rd,
    output logic               irq_line,
    output logic               irq_rx,
    output logic               irq_tx,
    output logic [IDENT_W-1:0] ident
);

    logic [N_SIMPLE-1:0] src_en;
    logic [N_SIMPLE-1:0] src_set;
    logic [N_SIMPLE-1:0] src_clr;
    logic [N_SIMPLE-1:0] src_pend;
    logic                tx_pend;
    logic                higher_pend;

    always_comb begin
        src_en[SRC_LINE]  = en_line;
        src_set[SRC_LINE] = |err_ev;
        src_clr[SRC_LINE] = linestat_rd;
        src_en[SRC_RX]    = en_rx;
        src_set[SRC_RX]   = rx_ready;
        src_clr[SRC_RX]   = rxbuf_rd;
    end

    // one set/clear machine per simple source
    for (genvar g = 0; g < N_SIMPLE; g++) begin : g_src
        irq_src_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (src_en[g]),
            .set_ev (src_set[g]),
            .clr_ev (src_clr[g]),
            .pend   (src_pend[g])
        );
    end

    always_comb begin
        higher_pend = |src_pend;
    end

    irq_tx_fsm u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (en_tx),
        .thr_empty   (thr_empty),
        .hold_wr     (hold_wr),
        .ident_rd    (ident_rd),
        .higher_pend (higher_pend),
        .pend        (tx_pend)
    );

    irq_ident_enc #(.IDENT_W(IDENT_W)) u_enc (
        .line_pend (src_pend[SRC_LINE]),
        .rx_pend   (src_pend[SRC_RX]),
        .tx_pend   (tx_pend),
        .ident     (ident)
    );

    always_comb begin
        irq_line = src_pend[SRC_LINE];
        irq_rx   = src_pend[SRC_RX];
        irq_tx   = tx_pend;
    end

    // R4: bit 0 low exactly when some request line is high
    a_r4_pending_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ident[0] == !(irq_line || irq_rx || irq_tx));

    // R3: a line error request always reports the line code
    a_r3_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line |-> (ident == IDENT_W'(6)));

    // R3: receive data outranks transmit empty
    a_r3_rx_over_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_line && irq_rx) |-> (ident == IDENT_W'(4)));

    // R2: with line errors disabled an error pulse raises nothing
    a_r2_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !en_line |=> !irq_line);

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

    localparam int ERR_W   = 4;
    localparam int IDENT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_line = 0, en_rx = 0, en_tx = 0;
    logic [ERR_W-1:0] err_ev = '0;
    logic             rx_ready = 0, thr_empty = 0, hold_wr = 0;
    logic             ident_rd = 0, rxbuf_rd = 0, linestat_rd = 0;
    logic             irq_line, irq_rx, irq_tx;
    logic [IDENT_W-1:0] ident;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    uart_irq_ident #(.ERR_W(ERR_W), .IDENT_W(IDENT_W)) uut (
        .clk(clk), .rst_n(rst_n), .en_line(en_line), .en_rx(en_rx), .en_tx(en_tx),
        .err_ev(err_ev), .rx_ready(rx_ready), .thr_empty(thr_empty),
        .hold_wr(hold_wr), .ident_rd(ident_rd), .rxbuf_rd(rxbuf_rd),
        .linestat_rd(linestat_rd), .irq_line(irq_line), .irq_rx(irq_rx),
        .irq_tx(irq_tx), .ident(ident)
    );

    // behavioural reference model
    bit m_line = 0, m_rx = 0, m_tx = 0, m_pen = 0, m_pthr = 0;

    function automatic int exp_ident();
        if (m_line)    return 6;
        else if (m_rx) return 4;
        else if (m_tx) return 2;
        else           return 1;
    endfunction

    always @(posedge clk) begin
        bit hi, arm;
        if (!rst_n) begin
            m_line = 0; m_rx = 0; m_tx = 0; m_pen = 0; m_pthr = 0;
        end else begin
            hi  = m_line || m_rx;
            arm = en_tx && thr_empty && !(m_pen && m_pthr);
            if (!en_tx || hold_wr)         m_tx = 0;
            else if (arm)                  m_tx = 1;
            else if (ident_rd && !hi)      m_tx = 0;
            if (!en_line)                  m_line = 0;
            else if (err_ev != 0)          m_line = 1;
            else if (linestat_rd)          m_line = 0;
            if (!en_rx)                    m_rx = 0;
            else if (rx_ready)             m_rx = 1;
            else if (rxbuf_rd)             m_rx = 0;
            m_pen = en_tx; m_pthr = thr_empty;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model (R1 R3 R4)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 cycle irq_line", irq_line, m_line);
            check("R1 cycle irq_rx", irq_rx, m_rx);
            check("R1 cycle irq_tx", irq_tx, m_tx);
            check("R3/R4 cycle ident", ident, exp_ident());
        end
    end

    // one clock: inputs already set after a negedge; return at the next negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        err_ev = '0; rx_ready = 0; hold_wr = 0;
        ident_rd = 0; rxbuf_rd = 0; linestat_rd = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        check("R12 irq_line", irq_line, 0);
        check("R12 irq_rx", irq_rx, 0);
        check("R12 irq_tx", irq_tx, 0);
        check("R12 ident", ident, 1);

        // R2 parity error with line enabled
        en_line = 1; err_ev = 4'b0010; tick();
        check("R2 line set", irq_line, 1);
        check("R3 line code", ident, 6);
        check("R1 rx untouched", irq_rx, 0);
        // R10 line status read
        linestat_rd = 1; tick();
        check("R10 line clear", irq_line, 0);
        check("R4 none", ident, 1);
        // R2 break ignored when disabled
        en_line = 0; err_ev = 4'b1000; tick();
        check("R2 disabled ignored", irq_line, 0);

        // R1 receive data
        en_rx = 1; rx_ready = 1; thr_empty = 1; tick();
        check("R1 rx set", irq_rx, 1);
        check("R3 rx code", ident, 4);
        // R5 enable rising over empty holding register
        en_tx = 1; tick();
        check("R5 tx armed", irq_tx, 1);
        check("R3 rx over tx", ident, 4);
        // R8 read at 0x04 keeps tx
        ident_rd = 1; tick();
        check("R8 keep at 04", irq_tx, 1);
        // R8 read at 0x06 keeps tx
        en_line = 1; err_ev = 4'b0001; tick();
        check("R3 line over rx", ident, 6);
        ident_rd = 1; tick();
        check("R8 keep at 06", irq_tx, 1);
        // R9 / R10 clear higher sources
        linestat_rd = 1; rxbuf_rd = 1; tick();
        check("R9 rx clear", irq_rx, 0);
        check("R3 tx code", ident, 2);
        // R7 read at 0x02 clears tx
        ident_rd = 1; tick();
        check("R7 read clears", irq_tx, 0);
        check("R4 idle again", ident, 1);

        // R5 empty rising while enabled
        thr_empty = 0; tick();
        thr_empty = 1; tick();
        check("R5 empty rise arms", irq_tx, 1);
        // R6 holding write clears
        hold_wr = 1; thr_empty = 0; tick();
        check("R6 write clears", irq_tx, 0);

        // R9 set wins over clear in same cycle
        rx_ready = 1; rxbuf_rd = 1; tick();
        check("R9 set wins", irq_rx, 1);
        // R11 disable drops rx
        en_rx = 0; tick();
        check("R11 rx disabled", irq_rx, 0);
        // R11 disable drops tx
        thr_empty = 1; tick();
        check("R5 rearm", irq_tx, 1);
        en_tx = 0; tick();
        check("R11 tx disabled", irq_tx, 0);
        // R11 disable drops line
        err_ev = 4'b0100; tick();
        check("R2 framing sets", irq_line, 1);
        en_line = 0; tick();
        check("R11 line disabled", irq_line, 0);

        repeat (2) tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule